// File: doc/BRIEF.md
# Ring-Pipelined Barrier Synchronizer

This block provides one global synchronization barrier for a set of processors whose nodes are linked in a ring. Each processor signals that it has reached the barrier with a one-cycle write strobe into its own node stage. That strobe goes first into a holding slot and then into the node's arrival flag. A single token carries a running AND around the ring. It moves one stage per hop, and neighbouring stages pass it with a request/acknowledge handshake. A master automaton sits between the last stage and the first. It launches every token pass and looks at the result when the token comes back.

A pass that returns false makes the master send a new check token straight away. A pass that returns true makes the master send a restart token instead. As the restart token goes through each node, that node clears its arrival flag and gives its processor a one-cycle release pulse. The nodes are released in ring order, one cycle apart. After the restart token comes back, the master resumes polling for the next barrier. The number of nodes is a parameter, with a default of 8.

Top module: `ring_barrier_sync`

## Requirements
- R1: While reset is held and after it is released, every release output stays low until all nodes have written an arrival strobe, and no arrival flag is set.
- R2: A strobe on `arrive_wr[i]` marks node i as arrived. The mark persists through any number of token passes until a restart clears it.
- R3: No release pulse appears on any node unless every node has written an arrival strobe since the previous release at that node.
- R4: Once the last node has written, `release_pulse[NODES-1]` rises within 4*(NODES+1)+4 clock cycles.
- R5: Each release is a single-cycle pulse. Each node receives exactly one pulse per completed barrier.
- R6: Within one barrier, node 0 is released first, and node i+1 is released exactly one cycle after node i.
- R7: A restart clears every arrival flag, so the next barrier again needs a fresh strobe from every node.
- R8: A strobe that a node samples on the same clock edge as the restart token reaching it, or on any later edge, counts toward the next barrier.
- R9: A stage or master that is offering a token keeps its request high and its token unchanged until the receiver acknowledges.
- R10: At most one token exists in the ring at any time.
- R11: A check token that returns false is followed by another check pass. A check token that returns true is followed by a restart pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock shared by all stages |
| rst | input | 1 | Synchronous active-high reset |
| arrive_wr | input | NODES | One-cycle arrival strobe, bit i from processor i |
| release_pulse | output | NODES | One-cycle registered release pulse, bit i to processor i |

## Verification
The main stimulus is a sweep over every proper subset of early arrivals. The nodes in a subset write first, and the bench confirms that nothing is released (R3). The complement then writes, and the bench checks the latency, the one-per-node count and the ring order of the release pulses. This separates a correct all-node AND from designs that drop a node, that release early, or that lose flags between passes. Staggered arrivals, one node every few cycles, force check passes to return false and confirm that the master keeps polling. A write timed to land exactly on the edge where the restart token reaches a node tells a double-buffered flag apart from one that the restart wipes out.

// File: rtl/barrier_ring_pkg.sv
package barrier_ring_pkg;

  typedef enum logic {
    TK_CHECK   = 1'b0,
    TK_RESTART = 1'b1
  } tok_kind_e;

  typedef struct packed {
    tok_kind_e kind;
    logic      all_in;
  } ring_tok_t;

endpackage

// File: rtl/rbs_node_stage.sv
module rbs_node_stage
  import barrier_ring_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      up_req,
  input  ring_tok_t up_tok,
  output logic      up_ack,
  output logic      dn_req,
  output ring_tok_t dn_tok,
  input  logic      dn_ack,
  input  logic      wr,
  output logic      release_o
);

  logic      full_q;
  ring_tok_t tok_q;
  logic      arrived_q;
  logic      pend_q;
  logic      rel_q;
  logic      take;
  logic      take_restart;

  assign up_ack       = up_req && !full_q;
  assign take         = up_ack;
  assign take_restart = take && (up_tok.kind == TK_RESTART);

  // token holding register with request/acknowledge toward the next stage
  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      tok_q  <= '{kind: TK_CHECK, all_in: 1'b0};
    end else if (take) begin
      full_q      <= 1'b1;
      tok_q.kind  <= up_tok.kind;
      tok_q.all_in <= (up_tok.kind == TK_CHECK) ? (up_tok.all_in && arrived_q)
                                                : up_tok.all_in;
    end else if (dn_ack) begin
      full_q <= 1'b0;
    end
  end

  // double-buffered arrival: the strobe lands in a pending slot and is merged
  // one edge later, so a restart on the same edge cannot swallow it
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      arrived_q <= 1'b0;
      rel_q     <= 1'b0;
    end else begin
      pend_q    <= wr || (pend_q && take_restart);
      arrived_q <= take_restart ? 1'b0 : (arrived_q || pend_q);
      rel_q     <= take_restart;
    end
  end

  assign dn_req    = full_q;
  assign dn_tok    = tok_q;
  assign release_o = rel_q;

  assert_release_single_R5: assert property (@(posedge clk) disable iff (rst)
    release_o |=> !release_o);

  assert_release_needs_arrival_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(release_o) |-> $past(arrived_q));

  assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (dn_req && !dn_ack) |=> (dn_req && $stable(dn_tok)));

endmodule

// File: rtl/rbs_master.sv
module rbs_master
  import barrier_ring_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ret_req,
  input  ring_tok_t ret_tok,
  output logic      ret_ack,
  output logic      out_req,
  output ring_tok_t out_tok,
  input  logic      out_ack
);

  logic      launching_q;
  tok_kind_e next_kind_q;

  assign ret_ack = ret_req && !launching_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      launching_q <= 1'b1;
      next_kind_q <= TK_CHECK;
    end else if (ret_ack) begin
      launching_q <= 1'b1;
      next_kind_q <= (ret_tok.kind == TK_CHECK && ret_tok.all_in) ? TK_RESTART
                                                                  : TK_CHECK;
    end else if (out_ack) begin
      launching_q <= 1'b0;
    end
  end

  assign out_req        = launching_q;
  assign out_tok.kind   = next_kind_q;
  assign out_tok.all_in = 1'b1;

  assert_false_repolls_R11: assert property (@(posedge clk) disable iff (rst)
    (ret_ack && ret_tok.kind == TK_CHECK && !ret_tok.all_in)
      |=> (out_req && out_tok.kind == TK_CHECK));

  assert_true_restarts_R11: assert property (@(posedge clk) disable iff (rst)
    (ret_ack && ret_tok.kind == TK_CHECK && ret_tok.all_in)
      |=> (out_req && out_tok.kind == TK_RESTART));

  assert_launch_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_req && !out_ack) |=> (out_req && $stable(out_tok)));

endmodule

// File: rtl/ring_barrier_sync.sv
module ring_barrier_sync
  import barrier_ring_pkg::*;
#(
  parameter int NODES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NODES-1:0] arrive_wr,
  output logic [NODES-1:0] release_pulse
);

  localparam int LAST = NODES - 1;

  logic      up_req_v [NODES];
  ring_tok_t up_tok_v [NODES];
  logic      up_ack_v [NODES];
  logic      dn_req_v [NODES];
  ring_tok_t dn_tok_v [NODES];
  logic      dn_ack_v [NODES];
  logic [NODES-1:0] stage_busy;

  logic      m_out_req;
  ring_tok_t m_out_tok;
  logic      m_ret_ack;

  rbs_master master_i (
    .clk     (clk),
    .rst     (rst),
    .ret_req (dn_req_v[LAST]),
    .ret_tok (dn_tok_v[LAST]),
    .ret_ack (m_ret_ack),
    .out_req (m_out_req),
    .out_tok (m_out_tok),
    .out_ack (up_ack_v[0])
  );

  for (genvar i = 0; i < NODES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign up_req_v[i] = m_out_req;
      assign up_tok_v[i] = m_out_tok;
    end else begin : g_link
      assign up_req_v[i]   = dn_req_v[i-1];
      assign up_tok_v[i]   = dn_tok_v[i-1];
      assign dn_ack_v[i-1] = up_ack_v[i];
    end

    rbs_node_stage stage_i (
      .clk       (clk),
      .rst       (rst),
      .up_req    (up_req_v[i]),
      .up_tok    (up_tok_v[i]),
      .up_ack    (up_ack_v[i]),
      .dn_req    (dn_req_v[i]),
      .dn_tok    (dn_tok_v[i]),
      .dn_ack    (dn_ack_v[i]),
      .wr        (arrive_wr[i]),
      .release_o (release_pulse[i])
    );

    assign stage_busy[i] = dn_req_v[i];
  end

  assign dn_ack_v[LAST] = m_ret_ack;

  assert_single_token_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({m_out_req, stage_busy}));

endmodule

// File: tb/ring_barrier_sync_tb_top.sv
module ring_barrier_sync_tb_top;

  localparam int N     = 8;
  localparam int BOUND = 4 * (N + 1) + 4;
  localparam int WIN   = BOUND + 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] arrive_wr = '0;
  logic [N-1:0] release_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit allow_rel = 1'b0;
  bit finished = 1'b0;
  int rel_cnt [N];
  int rel_cyc [N];
  int stray = 0;

  always #2 clk = ~clk;

  ring_barrier_sync #(.NODES(N)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .arrive_wr     (arrive_wr),
    .release_pulse (release_pulse)
  );

  // monitor samples mid-cycle
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < N; i++) begin
      if (release_pulse[i]) begin
        rel_cnt[i] = rel_cnt[i] + 1;
        rel_cyc[i] = cyc;
        if (!allow_rel) stray = stray + 1;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int i = 0; i < N; i++) begin
      rel_cnt[i] = 0;
      rel_cyc[i] = 0;
    end
    stray = 0;
  endtask

  function automatic int total_rel();
    int t = 0;
    for (int i = 0; i < N; i++) t += rel_cnt[i];
    return t;
  endfunction

  task automatic strobe(input logic [N-1:0] m);
    arrive_wr = m;
    step(1);
    arrive_wr = '0;
  endtask

  // expect no release after writing mask m
  task automatic expect_hold(input logic [N-1:0] m, input string tag);
    clear_counts();
    allow_rel = 1'b0;
    if (m != '0) strobe(m);
    step(WIN);
    check(total_rel() == 0 && stray == 0, tag, total_rel(), 0);
  endtask

  // write mask m, expect a full barrier release
  task automatic expect_release(input logic [N-1:0] m, input string tag);
    int wcyc;
    int first_bad;
    clear_counts();
    allow_rel = 1'b1;
    wcyc = cyc;
    if (m != '0) strobe(m);
    step(WIN);
    first_bad = -1;
    for (int i = 0; i < N; i++) if (rel_cnt[i] != 1 && first_bad < 0) first_bad = i;
    check(first_bad < 0, {tag, " R5 one pulse per node"},
          (first_bad < 0) ? 1 : rel_cnt[first_bad], 1);
    if (first_bad < 0) begin
      for (int i = 1; i < N; i++)
        check(rel_cyc[i] == rel_cyc[0] + i, {tag, " R6 ring order"},
              rel_cyc[i] - rel_cyc[0], i);
      check(rel_cyc[N-1] - wcyc <= BOUND, {tag, " R4 latency"},
            rel_cyc[N-1] - wcyc, BOUND);
    end
    allow_rel = 1'b0;
  endtask

  initial begin
    clear_counts();
    rst = 1'b1;
    step(4);
    check(release_pulse == '0, "R1 release low in reset", release_pulse, 0);
    rst = 1'b0;
    // R1: no arrivals, no release
    expect_hold('0, "R1 idle after reset");

    // R2 R3 R11: every proper subset arrives first, then the remainder
    for (int s = 0; s < (1 << N) - 1; s++) begin
      expect_hold(N'(s), "R3 partial arrival");
      expect_release(~N'(s), "R2 complement completes");
    end

    // R7: flags cleared after restart; all but last node is not enough
    expect_hold(~(N'(1) << (N-1)), "R7 flags cleared by restart");
    expect_release(N'(1) << (N-1), "R7 last node completes");

    // R11: staggered arrivals force false passes before success
    clear_counts();
    allow_rel = 1'b0;
    for (int i = N - 1; i > 0; i--) begin
      strobe(N'(1) << i);
      step(4);
    end
    check(total_rel() == 0 && stray == 0, "R11 staggered no early release", total_rel(), 0);
    expect_release(N'(1), "R11 staggered completes");

    // R8: writes at or after the restart edge count for the next barrier
    clear_counts();
    allow_rel = 1'b1;
    strobe('1);
    for (int k = 0; k < WIN && !release_pulse[0]; k++) step(1);
    check(release_pulse[0] == 1'b1, "R8 restart reached node 0", release_pulse[0], 1);
    arrive_wr = N'(3);   // node 0 after release, node 1 on its restart edge
    step(1);
    arrive_wr = '0;
    step(WIN);
    for (int i = 0; i < N; i++)
      check(rel_cnt[i] == 1, "R8 first barrier single release", rel_cnt[i], 1);
    allow_rel = 1'b0;
    expect_release(~N'(3), "R8 early writes retained");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule